// File: doc/BRIEF.md
# Set-Associative LRU Tag Store

This block is the tag array of a set-associative cache with exact least-recently-used replacement in each set. It holds a tag, a valid bit, a touched bit, a ready time and an owner bucket for every block. It also holds a recency rank for every way of every set. A single command port carries four operations: lookup, victim selection, insert and invalidate. The response comes back on the cycle after the command is accepted. For a lookup, the response reports hit or miss, the matching way and an access latency. The latency grows past the fixed hit latency while the block's fill is still outstanding.

A cache controller uses it as follows. It issues a lookup. On a miss it asks for a victim, refills the data elsewhere, and then inserts the new tag into the victim way. It tags each insert with the requesting context, or with none. The block keeps one occupancy counter per context bucket and one for unowned blocks. It raises a sticky warm-up flag, with the cycle it happened, once every block of the array has been filled at least once. Data, coherence state and writeback handling live outside.

The control is a two-state machine. In `ST_IDLE` the port is ready. A valid command is captured and takes the `IDLE_ACCEPT` transition to `ST_EXEC`. With no command, the `IDLE_WAIT` transition keeps the machine in `ST_IDLE`. `ST_EXEC` presents the response and commits all state updates at its closing edge, then always takes `EXEC_DONE` back to `ST_IDLE`.

Top module: `lru_tag_store`

## Requirements
- R1: After reset every block is invalid and every occupancy counter is zero. The warm-up flag is low. In each set the recency order puts way 0 as most recent and way WAYS-1 as least recent, so the first victim of any set is way WAYS-1 with victim-valid low. Any lookup misses.
- R2: With 16-byte blocks and 4 sets, address bits [3:0] are the offset and are ignored. Bits [5:4] select the set. Bits [15:6] form the tag. A lookup that differs only in offset bits hits the same way.
- R3: Command op 0 is lookup. A hit requires a valid block of the addressed set whose tag is equal. It reports rsp_hit=1 and the way, and moves that way to most recent. A miss reports rsp_hit=0 and leaves the order unchanged. rsp_hit is 0 for every other op.
- R4: On a hit, rsp_lat is HIT_LAT, unless the block's ready time is more than HIT_LAT cycles past the current cycle; then rsp_lat is the remaining count (ready time minus current cycle). Ready time is the insert's execute cycle plus cmd_fill. The cycle count starts at 0 at reset and advances on every clock edge. On a miss rsp_lat is 0.
- R5: Command op 1 (victim) returns in rsp_way the least-recent way of the addressed set, valid or not. rsp_vict_valid carries that block's valid bit. The recency order is not changed.
- R6: When the victim is valid, the counter of its owner bucket is decremented, but not below zero. The bucket is cmd_ctx mod NREQ from its insert, or bucket NREQ if unowned. The block then becomes unowned.
- R7: Command op 2 (insert) writes the tag into cmd_way of the addressed set and sets it valid. It records the owner bucket (cmd_ctx mod NREQ when cmd_owned=1, else NREQ) and increments that bucket's counter. It moves the way to most recent. Counter b is occ_o[b*CNT_W +: CNT_W].
- R8: An insert into a block that is not touched marks it touched and raises the in-use count. When the in-use count reaches SETS*WAYS while the flag is low, warm_o rises and warm_cycle_o holds the cycle of that insert. Both then stay unchanged.
- R9: Command op 3 (invalidate) clears valid and touched of cmd_way in the addressed set; a touched block lowers the in-use count. A valid block also decrements its owner bucket's counter (not below zero) and becomes unowned. An already invalid block leaves the counters unchanged.
- R10: cmd_ready is high exactly in the idle state. An accepted command gives rsp_valid high on the next cycle only, with cmd_ready low then. Only one command is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 2 | 0 lookup, 1 victim, 2 insert, 3 invalidate |
| cmd_addr | input | ADDR_W | Byte address |
| cmd_way | input | WAY_W | Target way for insert and invalidate |
| cmd_owned | input | 1 | Insert carries a requester context |
| cmd_ctx | input | CTX_W | Requester context of an insert |
| cmd_fill | input | FILL_W | Cycles until an inserted block is ready |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_way | output | WAY_W | Hit way, victim way, or target way |
| rsp_vict_valid | output | 1 | Chosen victim holds a valid block |
| rsp_lat | output | TIME_W | Effective lookup latency |
| occ_o | output | (NREQ+1)*CNT_W | Occupancy counters; unowned bucket highest |
| warm_o | output | 1 | Warm-up reached |
| warm_cycle_o | output | TIME_W | Cycle at which warm-up was reached |

## Verification
A corrupted recency rank shows up at the very next victim command on that set, as a wrong rsp_way. A wrong tag or valid bit shows on the next lookup as a false hit, a miss or a wrong way. A wrong owner bucket or ready time stays hidden until the block is evicted, invalidated or looked up. The counters are therefore compared after every command, and latency is probed immediately after inserts with long fills. A miscounted in-use total moves the warm-up edge and its latched cycle, which a full fill of the array exposes.

// File: rtl/lru_tag_pkg.sv
package lru_tag_pkg;

    typedef enum logic [1:0] {
        OP_LOOKUP = 2'd0,
        OP_VICTIM = 2'd1,
        OP_INSERT = 2'd2,
        OP_INVAL  = 2'd3
    } lru_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EXEC = 1'b1
    } lru_state_e;

endpackage

// File: rtl/lru_tag_match.sv
module lru_tag_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 10,
    parameter int WAY_W = 2
) (
    input  logic [WAYS*TAG_W-1:0] tags_i,
    input  logic [WAYS-1:0]       valid_i,
    input  logic [TAG_W-1:0]      tag_i,
    output logic                  hit_o,
    output logic [WAY_W-1:0]      way_o
);
    // lowest matching way wins
    always_comb begin
        hit_o = 1'b0;
        way_o = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!hit_o && valid_i[w] && (tags_i[w*TAG_W +: TAG_W] == tag_i)) begin
                hit_o = 1'b1;
                way_o = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/lru_rank_promote.sv
module lru_rank_promote #(
    parameter int WAYS  = 4,
    parameter int WAY_W = 2
) (
    input  logic [WAYS*WAY_W-1:0] rank_i,
    input  logic [WAY_W-1:0]      sel_i,
    output logic [WAYS*WAY_W-1:0] rank_o,
    output logic [WAY_W-1:0]      lru_o
);
    logic [WAY_W-1:0] sel_rank;
    assign sel_rank = rank_i[sel_i*WAY_W +: WAY_W];

    // rank 0 = most recent; ways more recent than the promoted one age by one
    for (genvar g = 0; g < WAYS; g++) begin : g_rank
        logic [WAY_W-1:0] cur;
        assign cur = rank_i[g*WAY_W +: WAY_W];
        assign rank_o[g*WAY_W +: WAY_W] =
            (sel_i == WAY_W'(g)) ? '0 :
            (cur < sel_rank)     ? cur + 1'b1 : cur;
    end

    always_comb begin
        lru_o = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (rank_i[w*WAY_W +: WAY_W] == WAY_W'(WAYS-1)) lru_o = WAY_W'(w);
        end
    end
endmodule

// File: rtl/lru_tag_store.sv
module lru_tag_store
    import lru_tag_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int BLK_BYTES = 16,
    parameter int SETS      = 4,
    parameter int WAYS      = 4,
    parameter int NREQ      = 2,
    parameter int CTX_W     = 3,
    parameter int HIT_LAT   = 2,
    parameter int TIME_W    = 24,
    parameter int FILL_W    = 8,
    localparam int OFF_W    = $clog2(BLK_BYTES),
    localparam int IDX_B    = $clog2(SETS),
    localparam int SET_W    = (SETS > 1) ? IDX_B : 1,
    localparam int TAG_W    = ADDR_W - OFF_W - IDX_B,
    localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int NBUCK    = NREQ + 1,
    localparam int OWN_W    = $clog2(NBUCK),
    localparam int BLOCKS   = SETS * WAYS,
    localparam int CNT_W    = $clog2(BLOCKS + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_valid,
    output logic                   cmd_ready,
    input  logic [1:0]             cmd_op,
    input  logic [ADDR_W-1:0]      cmd_addr,
    input  logic [WAY_W-1:0]       cmd_way,
    input  logic                   cmd_owned,
    input  logic [CTX_W-1:0]       cmd_ctx,
    input  logic [FILL_W-1:0]      cmd_fill,
    output logic                   rsp_valid,
    output logic                   rsp_hit,
    output logic [WAY_W-1:0]       rsp_way,
    output logic                   rsp_vict_valid,
    output logic [TIME_W-1:0]      rsp_lat,
    output logic [NBUCK*CNT_W-1:0] occ_o,
    output logic                   warm_o,
    output logic [TIME_W-1:0]      warm_cycle_o
);
    // elaboration-time parameter checks
    if (BLK_BYTES < 4 || (BLK_BYTES & (BLK_BYTES - 1)) != 0) begin : g_bad_blk
        $error("BLK_BYTES must be a power of two of at least 4");
    end
    if (SETS < 1 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
        $error("SETS must be a nonzero power of two");
    end
    if (WAYS < 1 || HIT_LAT < 1 || NREQ < 1) begin : g_bad_misc
        $error("WAYS, HIT_LAT and NREQ must be at least 1");
    end

    lru_state_e state_q, state_d;

    // captured command
    lru_op_e           op_q;
    logic [SET_W-1:0]  set_q;
    logic [TAG_W-1:0]  tag_cq;
    logic [WAY_W-1:0]  way_q;
    logic              owned_q;
    logic [CTX_W-1:0]  ctx_q;
    logic [FILL_W-1:0] fill_q;

    // per-block state
    logic [WAYS*TAG_W-1:0] tag_q   [SETS];
    logic [WAYS-1:0]       valid_q [SETS];
    logic [WAYS-1:0]       touch_q [SETS];
    logic [WAYS*WAY_W-1:0] rank_q  [SETS];
    logic [TIME_W-1:0]     ready_q [SETS][WAYS];
    logic [OWN_W-1:0]      own_q   [SETS][WAYS];

    logic [CNT_W-1:0]  occ_q [NBUCK];
    logic [CNT_W-1:0]  inuse_q;
    logic              warm_q;
    logic [TIME_W-1:0] warm_cyc_q;
    logic [TIME_W-1:0] cycle_q;

    // address split
    logic [SET_W-1:0] set_d;
    logic [TAG_W-1:0] tag_d;
    assign set_d = (IDX_B == 0) ? '0 : SET_W'(cmd_addr >> OFF_W);
    assign tag_d = TAG_W'(cmd_addr >> (OFF_W + IDX_B));

    // lookup and recency logic on the captured set
    logic                  hit;
    logic [WAY_W-1:0]      hit_way, lru_way, promote_way, tgt_way;
    logic [WAYS*WAY_W-1:0] rank_new;

    lru_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
        .tags_i (tag_q[set_q]),
        .valid_i(valid_q[set_q]),
        .tag_i  (tag_cq),
        .hit_o  (hit),
        .way_o  (hit_way)
    );

    assign promote_way = (op_q == OP_LOOKUP) ? hit_way : way_q;

    lru_rank_promote #(.WAYS(WAYS), .WAY_W(WAY_W)) u_rank (
        .rank_i(rank_q[set_q]),
        .sel_i (promote_way),
        .rank_o(rank_new),
        .lru_o (lru_way)
    );

    assign tgt_way = (op_q == OP_VICTIM) ? lru_way : way_q;

    logic              tgt_valid, tgt_touch;
    logic [OWN_W-1:0]  tgt_own, in_bucket;
    logic [TIME_W-1:0] hit_ready, remain, hit_lat;
    assign tgt_valid = valid_q[set_q][tgt_way];
    assign tgt_touch = touch_q[set_q][tgt_way];
    assign tgt_own   = own_q[set_q][tgt_way];
    assign in_bucket = owned_q ? OWN_W'(32'(ctx_q) % NREQ) : OWN_W'(NREQ);
    assign hit_ready = ready_q[set_q][hit_way];
    assign remain    = hit_ready - cycle_q;
    assign hit_lat   = (hit_ready > cycle_q && remain > TIME_W'(HIT_LAT)) ? remain : TIME_W'(HIT_LAT);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = cmd_valid ? ST_EXEC : ST_IDLE;   // IDLE_ACCEPT / IDLE_WAIT
            ST_EXEC: state_d = ST_IDLE;                         // EXEC_DONE
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cmd_ready      = 1'b0;
        rsp_valid      = 1'b0;
        rsp_hit        = 1'b0;
        rsp_way        = '0;
        rsp_vict_valid = 1'b0;
        rsp_lat        = '0;
        unique case (state_q)
            ST_IDLE: cmd_ready = 1'b1;
            ST_EXEC: begin
                rsp_valid = 1'b1;
                unique case (op_q)
                    OP_LOOKUP: begin
                        rsp_hit = hit;
                        rsp_way = hit ? hit_way : '0;
                        rsp_lat = hit ? hit_lat : '0;
                    end
                    OP_VICTIM: begin
                        rsp_way        = lru_way;
                        rsp_vict_valid = tgt_valid;
                    end
                    default: rsp_way = way_q;
                endcase
            end
            default: ;
        endcase
    end

    for (genvar b = 0; b < NBUCK; b++) begin : g_occ
        assign occ_o[b*CNT_W +: CNT_W] = occ_q[b];
    end
    assign warm_o       = warm_q;
    assign warm_cycle_o = warm_cyc_q;

    // command capture, storage update, counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= OP_LOOKUP;
            set_q   <= '0;
            tag_cq  <= '0;
            way_q   <= '0;
            owned_q <= 1'b0;
            ctx_q   <= '0;
            fill_q  <= '0;
            for (int s = 0; s < SETS; s++) begin
                tag_q[s]   <= '0;
                valid_q[s] <= '0;
                touch_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    rank_q[s][w*WAY_W +: WAY_W] <= WAY_W'(w);
                    ready_q[s][w] <= '0;
                    own_q[s][w]   <= OWN_W'(NREQ);
                end
            end
            for (int b = 0; b < NBUCK; b++) occ_q[b] <= '0;
            inuse_q    <= '0;
            warm_q     <= 1'b0;
            warm_cyc_q <= '0;
            cycle_q    <= '0;
        end else begin
            cycle_q <= cycle_q + 1'b1;
            if (state_q == ST_IDLE && cmd_valid) begin
                op_q    <= lru_op_e'(cmd_op);
                set_q   <= set_d;
                tag_cq  <= tag_d;
                way_q   <= cmd_way;
                owned_q <= cmd_owned;
                ctx_q   <= cmd_ctx;
                fill_q  <= cmd_fill;
            end
            if (state_q == ST_EXEC) begin
                unique case (op_q)
                    OP_LOOKUP: if (hit) rank_q[set_q] <= rank_new;
                    OP_VICTIM: if (tgt_valid) begin
                        if (occ_q[tgt_own] != 0) occ_q[tgt_own] <= occ_q[tgt_own] - 1'b1;
                        own_q[set_q][tgt_way] <= OWN_W'(NREQ);
                    end
                    OP_INSERT: begin
                        tag_q[set_q][tgt_way*TAG_W +: TAG_W] <= tag_cq;
                        valid_q[set_q][tgt_way] <= 1'b1;
                        own_q[set_q][tgt_way]   <= in_bucket;
                        ready_q[set_q][tgt_way] <= cycle_q + TIME_W'(fill_q);
                        occ_q[in_bucket]        <= occ_q[in_bucket] + 1'b1;
                        rank_q[set_q]           <= rank_new;
                        if (!tgt_touch) begin
                            touch_q[set_q][tgt_way] <= 1'b1;
                            inuse_q <= inuse_q + 1'b1;
                            if (!warm_q && (inuse_q + 1'b1) >= CNT_W'(BLOCKS)) begin
                                warm_q     <= 1'b1;
                                warm_cyc_q <= cycle_q;
                            end
                        end
                    end
                    OP_INVAL: begin
                        valid_q[set_q][tgt_way] <= 1'b0;
                        touch_q[set_q][tgt_way] <= 1'b0;
                        if (tgt_touch && inuse_q != 0) inuse_q <= inuse_q - 1'b1;
                        if (tgt_valid) begin
                            if (occ_q[tgt_own] != 0) occ_q[tgt_own] <= occ_q[tgt_own] - 1'b1;
                            own_q[set_q][tgt_way] <= OWN_W'(NREQ);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/lru_tag_store_chk.sv
module lru_tag_store_chk #(
    parameter int HIT_LAT = 2,
    parameter int TIME_W  = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [TIME_W-1:0] rsp_lat,
    input logic              warm_o,
    input logic [TIME_W-1:0] warm_cycle_o,
    input logic [1:0]        op_q
);
    // R10
    accept_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> rsp_valid);

    // R10
    rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R10
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !cmd_ready);

    // R4
    lat_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> (rsp_lat >= TIME_W'(HIT_LAT)));

    // R3
    hit_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && op_q != 2'd0) |-> !rsp_hit);

    // R8
    warm_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        warm_o |=> (warm_o && $stable(warm_cycle_o)));
endmodule

bind lru_tag_store lru_tag_store_chk #(.HIT_LAT(HIT_LAT), .TIME_W(TIME_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .rsp_valid   (rsp_valid),
    .rsp_hit     (rsp_hit),
    .rsp_lat     (rsp_lat),
    .warm_o      (warm_o),
    .warm_cycle_o(warm_cycle_o),
    .op_q        (op_q)
);

// File: tb/lru_tag_store_tb.sv
module lru_tag_store_tb;
    localparam int HIT   = 2;
    localparam int TW    = 24;
    localparam int CW    = 5;
    localparam int NB    = 3;

    logic          clk, rst_n;
    logic          cmd_valid, cmd_ready, cmd_owned;
    logic [1:0]    cmd_op, cmd_way;
    logic [15:0]   cmd_addr;
    logic [2:0]    cmd_ctx;
    logic [7:0]    cmd_fill;
    logic          rsp_valid, rsp_hit, rsp_vict_valid;
    logic [1:0]    rsp_way;
    logic [TW-1:0] rsp_lat, warm_cycle_o;
    logic [NB*CW-1:0] occ_o;
    logic          warm_o;

    lru_tag_store #(.ADDR_W(16), .BLK_BYTES(16), .SETS(4), .WAYS(4), .NREQ(2),
                    .CTX_W(3), .HIT_LAT(HIT), .TIME_W(TW), .FILL_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_way(cmd_way), .cmd_owned(cmd_owned),
        .cmd_ctx(cmd_ctx), .cmd_fill(cmd_fill), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_way(rsp_way), .rsp_vict_valid(rsp_vict_valid), .rsp_lat(rsp_lat),
        .occ_o(occ_o), .warm_o(warm_o), .warm_cycle_o(warm_cycle_o)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    int n_chk = 0, n_fail = 0, tcyc = 0;
    bit done = 0;

    always @(posedge clk or negedge rst_n)
        if (!rst_n) tcyc <= 0; else tcyc <= tcyc + 1;

    // reference model
    int m_tag [4][4], m_rank [4][4], m_ready [4][4], m_own [4][4];
    bit m_val [4][4], m_touch [4][4];
    int m_occ [NB], m_inuse, m_wcyc;
    bit m_warm;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int m_lru(input int s);
        for (int w = 0; w < 4; w++) if (m_rank[s][w] == 3) return w;
        return 0;
    endfunction

    task automatic m_promote(input int s, input int p);
        int pr = m_rank[s][p];
        for (int w = 0; w < 4; w++) begin
            if (w == p) m_rank[s][w] = 0;
            else if (m_rank[s][w] < pr) m_rank[s][w]++;
        end
    endtask

    task automatic do_cmd(input int op, input int addr, input int way,
                          input bit owned, input int ctx, input int fill);
        int s, t, hw, vw, now, elat, b;
        bit hit;
        string rq;
        cmd_op = op[1:0]; cmd_addr = addr[15:0]; cmd_way = way[1:0];
        cmd_owned = owned; cmd_ctx = ctx[2:0]; cmd_fill = fill[7:0]; cmd_valid = 1'b1;
        chk(cmd_ready === 1'b1, "R10", "ready_idle", cmd_ready, 1);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(rsp_valid === 1'b1 && cmd_ready === 1'b0, "R10", "rsp_cycle", rsp_valid, 1);
        now = tcyc; s = (addr >> 4) & 3; t = addr >> 6;
        case (op)
            0: begin
                rq = "R3"; hit = 0; hw = 0;
                for (int w = 0; w < 4; w++)
                    if (!hit && m_val[s][w] && m_tag[s][w] == t) begin hit = 1; hw = w; end
                chk(rsp_hit == hit, "R3", "hit", rsp_hit, hit);
                if (hit) begin
                    chk(rsp_way == hw[1:0], "R3", "hit_way", rsp_way, hw);
                    elat = (m_ready[s][hw] > now && m_ready[s][hw] - now > HIT) ? m_ready[s][hw] - now : HIT;
                    m_promote(s, hw);
                end else elat = 0;
                chk(rsp_lat == elat, "R4", "latency", rsp_lat, elat);
            end
            1: begin
                rq = "R6"; vw = m_lru(s);
                chk(rsp_way == vw[1:0], "R5", "victim_way", rsp_way, vw);
                chk(rsp_vict_valid == m_val[s][vw], "R5", "victim_valid", rsp_vict_valid, m_val[s][vw]);
                if (m_val[s][vw]) begin
                    if (m_occ[m_own[s][vw]] > 0) m_occ[m_own[s][vw]]--;
                    m_own[s][vw] = 2;
                end
            end
            2: begin
                rq = "R7";
                b = owned ? ctx % 2 : 2;
                m_tag[s][way] = t; m_val[s][way] = 1; m_own[s][way] = b;
                m_ready[s][way] = now + fill; m_occ[b]++;
                m_promote(s, way);
                if (!m_touch[s][way]) begin
                    m_touch[s][way] = 1; m_inuse++;
                    if (!m_warm && m_inuse >= 16) begin m_warm = 1; m_wcyc = now; end
                end
            end
            default: begin
                rq = "R9";
                if (m_val[s][way]) begin
                    if (m_occ[m_own[s][way]] > 0) m_occ[m_own[s][way]]--;
                    m_own[s][way] = 2;
                end
                if (m_touch[s][way] && m_inuse > 0) m_inuse--;
                m_val[s][way] = 0; m_touch[s][way] = 0;
            end
        endcase
        @(negedge clk);
        for (int k = 0; k < NB; k++)
            chk(occ_o[k*CW +: CW] == m_occ[k][CW-1:0], rq, "occupancy", occ_o[k*CW +: CW], m_occ[k]);
        chk(warm_o == m_warm, "R8", "warm", warm_o, m_warm);
        if (m_warm) chk(warm_cycle_o == m_wcyc[TW-1:0], "R8", "warm_cycle", warm_cycle_o, m_wcyc);
    endtask

    function automatic int mk(input int s, input int t, input int off);
        return (t << 6) | (s << 4) | (off & 15);
    endfunction

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int vw, t;
        rst_n = 0; cmd_valid = 0; cmd_op = 0; cmd_addr = 0; cmd_way = 0;
        cmd_owned = 0; cmd_ctx = 0; cmd_fill = 0;
        for (int s = 0; s < 4; s++)
            for (int w = 0; w < 4; w++) begin
                m_tag[s][w] = 0; m_rank[s][w] = w; m_ready[s][w] = 0;
                m_own[s][w] = 2; m_val[s][w] = 0; m_touch[s][w] = 0;
            end
        for (int k = 0; k < NB; k++) m_occ[k] = 0;
        m_inuse = 0; m_wcyc = 0; m_warm = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state at the ports
        chk(cmd_ready === 1'b1 && rsp_valid === 1'b0, "R1", "idle_after_reset", cmd_ready, 1);
        chk(occ_o == '0, "R1", "occ_zero", occ_o, 0);
        chk(warm_o == 1'b0, "R1", "warm_low", warm_o, 0);
        // R1 / R5: first victim is last way, invalid; lookups miss
        for (int s = 0; s < 4; s++) do_cmd(1, mk(s, 0, 0), 0, 0, 0, 0);
        for (int s = 0; s < 4; s++) do_cmd(0, mk(s, 5, s), 0, 0, 0, 0);

        // R7 / R8: fill every block through victim + insert; warm-up on the 16th
        for (int s = 0; s < 4; s++)
            for (int k = 0; k < 4; k++) begin
                vw = m_lru(s);
                do_cmd(1, mk(s, 0, 0), 0, 0, 0, 0);
                do_cmd(2, mk(s, s*7 + k + 1, 0), vw, k != 3, s + 2*k + 1, k*5);
            end

        // R2 / R3 / R4: lookups with varied offsets, every block
        for (int s = 0; s < 4; s++)
            for (int k = 0; k < 4; k++)
                do_cmd(0, mk(s, s*7 + k + 1, k*5 + s + 3), 0, 0, 0, 0);

        // R3 / R5: recency permutations followed by victim, then a miss leaves order
        for (int s = 0; s < 4; s++) begin
            for (int k = 0; k < 4; k++) do_cmd(0, mk(s, s*7 + ((k*3 + s) % 4) + 1, 0), 0, 0, 0, 0);
            do_cmd(1, mk(s, 0, 0), 0, 0, 0, 0);
            do_cmd(0, mk(s, 900, 1), 0, 0, 0, 0);
            do_cmd(1, mk(s, 0, 0), 0, 0, 0, 0);
        end

        // R4: long fill then immediate lookups; short and zero fills give HIT_LAT
        vw = m_lru(0);
        do_cmd(1, mk(0, 0, 0), 0, 0, 0, 0);
        do_cmd(2, mk(0, 200, 0), vw, 1, 5, 40);
        do_cmd(0, mk(0, 200, 7), 0, 0, 0, 0);
        do_cmd(0, mk(0, 200, 9), 0, 0, 0, 0);
        vw = m_lru(0);
        do_cmd(1, mk(0, 0, 0), 0, 0, 0, 0);
        do_cmd(2, mk(0, 201, 0), vw, 0, 0, 3);
        do_cmd(0, mk(0, 201, 0), 0, 0, 0, 0);
        vw = m_lru(0);
        do_cmd(1, mk(0, 0, 0), 0, 0, 0, 0);
        do_cmd(2, mk(0, 202, 0), vw, 1, 2, 0);
        do_cmd(0, mk(0, 202, 0), 0, 0, 0, 0);
        vw = m_lru(0);
        do_cmd(1, mk(0, 0, 0), 0, 0, 0, 0);
        do_cmd(2, mk(0, 203, 0), vw, 1, 7, 4);
        do_cmd(0, mk(0, 203, 0), 0, 0, 0, 0);

        // R9: invalidate valid blocks, then invalid ones; counters and lookups
        for (int s = 1; s < 4; s++) begin
            t = s*7 + 2;
            for (int w = 0; w < 4; w++)
                if (m_val[s][w] && m_tag[s][w] == t) vw = w;
            do_cmd(3, mk(s, t, 0), vw, 0, 0, 0);
            do_cmd(0, mk(s, t, 0), 0, 0, 0, 0);
            do_cmd(3, mk(s, t, 0), vw, 0, 0, 0);
            // R8: re-insert into the untouched block; warm flag stays
            do_cmd(2, mk(s, 500 + s, 0), vw, 1, s, 1);
            do_cmd(0, mk(s, 500 + s, 2), 0, 0, 0, 0);
        end
        // R5: victim of an invalidated LRU block reports invalid
        do_cmd(3, mk(2, 0, 0), m_lru(2), 0, 0, 0);
        do_cmd(1, mk(2, 0, 0), 0, 0, 0, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule